// File: doc/BRIEF.md
# Sleep/Wake Power Status Controller

This block keeps the power-management status of a system and the small state machine that follows its power state: running, sleeping, or forced soft-off. Three hardware events are captured as sticky flags that software clears by writing ones: a wake from sleep, a forced power-off, and a real-time-clock alarm. While the system sleeps, enabled events end the sleep and raise a one-cycle wake request. A power button held for a set number of slow ticks forces soft-off. An override message or a thermal trip does the same at once.

Three reset inputs model the retention domains. `por` clears everything. `resume_rst` clears the resume-well flags but keeps the forced-off history. `hard_rst` keeps every status flag and only clears the enables and the state. A flag records that power was lost after a forced shutdown. When power returns outside sleep, this flag decides whether the wake flag is raised.

Software reaches the block through a word-wide register port with a registered read. Status is at offset 00h, enables at 02h, and control at 04h. Every other offset reads zero.

Top module: `pwr_wake_status`

## Requirements
- R1: After `por`, every register reads 0000h, `pwr_state` is 0 (running) and `wake_req` is 0. State encoding: 0 running, 1 sleeping, 2 soft-off.
- R2: In each register, the bits not listed in R3, R6 or R12 read 0, and writes to them are ignored. Unmapped offsets read 0000h.
- R3: Status bits 15 (wake), 11 (forced-off) and 10 (alarm) are set only by hardware. Writing 1 to a bit at offset 00h clears it, and writing 0 leaves it unchanged.
- R4: If a hardware set and a software clear hit the same status bit in one cycle, the bit ends up set.
- R5: An alarm pulse sets status bit 10 in any state, whatever the enables hold.
- R6: Writing 1 to control bit 0 (offset 04h) while running enters sleep. In sleep, an alarm with enable bit 10 set, or an external wake with enable bit 8 set (offset 02h), returns the state to running, sets status bit 15 and pulses `wake_req` for one cycle. Disabled events leave the system asleep.
- R7: Status bit 15 is never set by a wake event outside sleep. An enabled event in soft-off returns the state to running without setting it.
- R8: With the button held, `HOLD_TICKS` slow ticks force an override. Releasing the button earlier restarts the count, and a continuing hold fires only once.
- R9: A timed hold, an override message or a thermal trip moves the state to soft-off, sets status bit 11 and sets control bit 1 (lost-power flag). This takes priority over wake and sleep in the same cycle.
- R10: `hard_rst` keeps all three status bits and control bit 1. It clears the enables, returns the state to running and zeroes the read data.
- R11: `resume_rst` clears status bits 15 and 10 and the enables. It keeps status bit 11 and control bit 1.
- R12: A `power_restore` pulse outside sleep sets status bit 15 and moves to running only when control bit 1 is 1. Control bit 1 is also software read/write.
- R13: Read data appears one cycle after the address and shows register contents from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, clears everything (sync, high) |
| resume_rst | input | 1 | Resume-well reset (sync, high) |
| hard_rst | input | 1 | Platform hard reset (sync, high) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| rtc_alarm | input | 1 | Alarm pulse |
| ext_wake | input | 1 | External wake event pulse |
| btn_held | input | 1 | Power button level, synchronised |
| slow_tick | input | 1 | Slow time-base tick for hold timing |
| ovr_msg | input | 1 | Override message pulse |
| therm_trip | input | 1 | Catastrophic thermal pulse |
| power_restore | input | 1 | Power returned after a loss |
| pwr_state | output | 2 | Current power state |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The hardest cases to reach are the retention rules. The bench must first build a known mix of set flags, then apply each reset class and read the survivors back. It must also bring conflicting events into one cycle: sleep entry, a wake event and a thermal trip together, or a hardware set beside a write-one clear. The hold timer is driven with an early release followed by a full hold that continues past firing. A behavioural model, updated on every edge, predicts read data, state and wake request through all of these sequences.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PS_ON      = 2'd0,
    PS_SLEEP   = 2'd1,
    PS_SOFTOFF = 2'd2
  } pwr_state_e;

  localparam int REG_W         = 16;
  localparam int STS_WAKE_BIT  = 15;
  localparam int STS_OVR_BIT   = 11;
  localparam int STS_ALARM_BIT = 10;
  localparam int EN_ALARM_BIT  = 10;
  localparam int EN_EXT_BIT    = 8;
  localparam int CTL_SLEEP_BIT = 0;
  localparam int CTL_LOSS_BIT  = 1;

  localparam int OFS_STATUS = 'h00;
  localparam int OFS_ENABLE = 'h02;
  localparam int OFS_CTRL   = 'h04;
endpackage

// File: rtl/pws_hold_timer.sv
module pws_hold_timer #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic held,
  input  logic tick,
  output logic fire
);
  localparam int CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  // a held button fires once per press; release rearms
  assign fire = held && tick && !done_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!held) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pws_power_fsm.sv
module pws_power_fsm
  import pwr_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ovr,
  input  logic       wake_hit,
  input  logic       sleep_go,
  input  logic       restore,
  input  logic       loss_flag,
  output pwr_state_e state,
  output logic       wake_req,
  output logic       wak_set
);
  pwr_state_e state_n;
  logic       wake_req_n;

  always_comb begin
    state_n    = state;
    wak_set    = 1'b0;
    wake_req_n = 1'b0;
    if (ovr) begin
      state_n = PS_SOFTOFF;
    end else begin
      case (state)
        PS_ON: begin
          if (restore && loss_flag) wak_set = 1'b1;
          else if (sleep_go)        state_n = PS_SLEEP;
        end
        PS_SLEEP: begin
          if (wake_hit) begin
            state_n    = PS_ON;
            wak_set    = 1'b1;
            wake_req_n = 1'b1;
          end
        end
        PS_SOFTOFF: begin
          if (wake_hit) begin
            state_n = PS_ON;
          end else if (restore && loss_flag) begin
            state_n = PS_ON;
            wak_set = 1'b1;
          end
        end
        default: state_n = PS_ON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_ON;
      wake_req <= 1'b0;
    end else begin
      state    <= state_n;
      wake_req <= wake_req_n;
    end
  end
endmodule

// File: rtl/pws_status_regs.sv
module pws_status_regs
  import pwr_wake_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              por,
  input  logic              resume_rst,
  input  logic              hard_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              ovr,
  input  logic              alarm,
  input  logic              wak_set,
  output logic [REG_W-1:0]  rd_data,
  output logic              alarm_en,
  output logic              ext_en,
  output logic              loss_flag,
  output logic              sleep_go,
  output logic              sts_wak,
  output logic              sts_ovr,
  output logic              sts_alarm
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTRL);

  logic wr_sts, wr_en_reg, wr_ctl;
  logic [REG_W-1:0] rd_next;
  logic unused_wdata;

  assign unused_wdata = ^wr_data;
  assign wr_sts    = wr_en && (addr == A_STS);
  assign wr_en_reg = wr_en && (addr == A_EN);
  assign wr_ctl    = wr_en && (addr == A_CTL);
  assign sleep_go  = wr_ctl && wr_data[CTL_SLEEP_BIT];

  // forced-off history and lost-power flag: cleared only at power-on
  always_ff @(posedge clk) begin
    if (por) begin
      sts_ovr   <= 1'b0;
      loss_flag <= 1'b0;
    end else if (!resume_rst && !hard_rst) begin
      sts_ovr   <= (sts_ovr && !(wr_sts && wr_data[STS_OVR_BIT])) || ovr;
      loss_flag <= (wr_ctl ? wr_data[CTL_LOSS_BIT] : loss_flag) || ovr;
    end
  end

  // resume-well flags: survive a hard reset
  always_ff @(posedge clk) begin
    if (por || resume_rst) begin
      sts_wak   <= 1'b0;
      sts_alarm <= 1'b0;
    end else if (!hard_rst) begin
      sts_wak   <= (sts_wak && !(wr_sts && wr_data[STS_WAKE_BIT])) || wak_set;
      sts_alarm <= (sts_alarm && !(wr_sts && wr_data[STS_ALARM_BIT])) || alarm;
    end
  end

  // enables: cleared by every reset class
  always_ff @(posedge clk) begin
    if (por || resume_rst || hard_rst) begin
      alarm_en <= 1'b0;
      ext_en   <= 1'b0;
    end else if (wr_en_reg) begin
      alarm_en <= wr_data[EN_ALARM_BIT];
      ext_en   <= wr_data[EN_EXT_BIT];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_STS) begin
      rd_next[STS_WAKE_BIT]  = sts_wak;
      rd_next[STS_OVR_BIT]   = sts_ovr;
      rd_next[STS_ALARM_BIT] = sts_alarm;
    end else if (addr == A_EN) begin
      rd_next[EN_ALARM_BIT] = alarm_en;
      rd_next[EN_EXT_BIT]   = ext_en;
    end else if (addr == A_CTL) begin
      rd_next[CTL_LOSS_BIT] = loss_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (por || resume_rst || hard_rst) rd_data <= '0;
    else                               rd_data <= rd_next;
  end
endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status
  import pwr_wake_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int HOLD_TICKS = 4
) (
  input  logic              clk,
  input  logic              por,
  input  logic              resume_rst,
  input  logic              hard_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              rtc_alarm,
  input  logic              ext_wake,
  input  logic              btn_held,
  input  logic              slow_tick,
  input  logic              ovr_msg,
  input  logic              therm_trip,
  input  logic              power_restore,
  output logic [1:0]        pwr_state,
  output logic              wake_req
);
  logic any_rst, hold_fire, ovr, wake_hit, wak_set;
  logic alarm_en, ext_en, loss_flag, sleep_go;
  logic sts_wak, sts_ovr, sts_alarm;
  pwr_state_e state;

  assign any_rst  = por || resume_rst || hard_rst;
  assign ovr      = hold_fire || ovr_msg || therm_trip;
  assign wake_hit = (rtc_alarm && alarm_en) || (ext_wake && ext_en);
  assign pwr_state = state;

  pws_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk  (clk),
    .rst  (any_rst),
    .held (btn_held),
    .tick (slow_tick),
    .fire (hold_fire)
  );

  pws_power_fsm u_fsm (
    .clk       (clk),
    .rst       (any_rst),
    .ovr       (ovr),
    .wake_hit  (wake_hit),
    .sleep_go  (sleep_go),
    .restore   (power_restore),
    .loss_flag (loss_flag),
    .state     (state),
    .wake_req  (wake_req),
    .wak_set   (wak_set)
  );

  pws_status_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .por        (por),
    .resume_rst (resume_rst),
    .hard_rst   (hard_rst),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wr_data    (reg_wdata),
    .ovr        (ovr),
    .alarm      (rtc_alarm),
    .wak_set    (wak_set),
    .rd_data    (reg_rdata),
    .alarm_en   (alarm_en),
    .ext_en     (ext_en),
    .loss_flag  (loss_flag),
    .sleep_go   (sleep_go),
    .sts_wak    (sts_wak),
    .sts_ovr    (sts_ovr),
    .sts_alarm  (sts_alarm)
  );
endmodule

// File: rtl/pwr_wake_status_chk.sv
module pwr_wake_status_chk (
  input logic        clk,
  input logic        por,
  input logic        resume_rst,
  input logic        hard_rst,
  input logic        ovr_msg,
  input logic        therm_trip,
  input logic        rtc_alarm,
  input logic [15:0] reg_rdata,
  input logic [1:0]  pwr_state,
  input logic        wake_req,
  input logic        sts_wak,
  input logic        sts_ovr,
  input logic        sts_alarm
);
  logic any_rst;
  assign any_rst = por || resume_rst || hard_rst;

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (any_rst)
    (reg_rdata & ~16'h8D02) == 16'h0000);

  p_state_legal_r1: assert property (@(posedge clk) disable iff (any_rst)
    pwr_state != 2'd3);

  p_alarm_latch_r5: assert property (@(posedge clk) disable iff (any_rst)
    rtc_alarm |=> sts_alarm);

  p_wake_from_sleep_r6: assert property (@(posedge clk) disable iff (any_rst)
    wake_req |-> ($past(pwr_state) == 2'd1 && pwr_state == 2'd0));

  p_wake_sets_flag_r6: assert property (@(posedge clk) disable iff (any_rst)
    wake_req |-> sts_wak);

  p_override_s5_r9: assert property (@(posedge clk) disable iff (any_rst)
    (ovr_msg || therm_trip) |=> (pwr_state == 2'd2 && sts_ovr));

  p_ovr_kept_r11: assert property (@(posedge clk) disable iff (por)
    ((resume_rst || hard_rst) && sts_ovr) |=> sts_ovr);
endmodule

bind pwr_wake_status pwr_wake_status_chk u_chk (
  .clk        (clk),
  .por        (por),
  .resume_rst (resume_rst),
  .hard_rst   (hard_rst),
  .ovr_msg    (ovr_msg),
  .therm_trip (therm_trip),
  .rtc_alarm  (rtc_alarm),
  .reg_rdata  (reg_rdata),
  .pwr_state  (pwr_state),
  .wake_req   (wake_req),
  .sts_wak    (sts_wak),
  .sts_ovr    (sts_ovr),
  .sts_alarm  (sts_alarm)
);

// File: tb/pwr_wake_status_tb.sv
`timescale 1ns/1ps
module pwr_wake_status_tb;
  localparam int HOLD = 4;
  localparam int AW   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por = 1'b1, resume_rst = 1'b0, hard_rst = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic rtc_alarm = 0, ext_wake = 0, btn_held = 0, slow_tick = 0;
  logic ovr_msg = 0, therm_trip = 0, power_restore = 0;
  logic [1:0] pwr_state;
  logic wake_req;

  pwr_wake_status #(.ADDR_W(AW), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .por(por), .resume_rst(resume_rst), .hard_rst(hard_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rtc_alarm(rtc_alarm), .ext_wake(ext_wake),
    .btn_held(btn_held), .slow_tick(slow_tick), .ovr_msg(ovr_msg),
    .therm_trip(therm_trip), .power_restore(power_restore),
    .pwr_state(pwr_state), .wake_req(wake_req)
  );

  // behavioural reference
  bit m_wak, m_prb, m_rtc, m_rten, m_exen, m_ag3, m_done, m_wreq;
  int m_state, m_cnt;
  logic [15:0] m_rd;
  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit finished = 0;

  function automatic logic [15:0] model_read(input logic [AW-1:0] a);
    logic [15:0] v = 16'h0;
    if (a == 8'h00) begin v[15] = m_wak; v[11] = m_prb; v[10] = m_rtc; end
    else if (a == 8'h02) begin v[10] = m_rten; v[8] = m_exen; end
    else if (a == 8'h04) v[1] = m_ag3;
    return v;
  endfunction

  task automatic model_step();
    bit fire, ovr, hit, wset, sgo;
    int st_n;
    if (por || resume_rst || hard_rst) begin
      if (por) begin m_prb = 0; m_ag3 = 0; end
      if (por || resume_rst) begin m_wak = 0; m_rtc = 0; end
      m_rten = 0; m_exen = 0; m_state = 0; m_cnt = 0; m_done = 0;
      m_rd = 0; m_wreq = 0;
      return;
    end
    m_rd = model_read(reg_addr);
    fire = btn_held && slow_tick && !m_done && (m_cnt == HOLD - 1);
    if (!btn_held) begin m_cnt = 0; m_done = 0; end
    else if (slow_tick && !m_done) begin
      if (m_cnt == HOLD - 1) begin m_cnt = 0; m_done = 1; end
      else m_cnt++;
    end
    ovr  = fire || ovr_msg || therm_trip;
    hit  = (rtc_alarm && m_rten) || (ext_wake && m_exen);
    sgo  = reg_wr && reg_addr == 8'h04 && reg_wdata[0];
    wset = 0; st_n = m_state; m_wreq = 0;
    if (ovr) st_n = 2;
    else if (m_state == 0) begin
      if (power_restore && m_ag3) wset = 1;
      else if (sgo) st_n = 1;
    end else if (m_state == 1) begin
      if (hit) begin st_n = 0; wset = 1; m_wreq = 1; end
    end else begin
      if (hit) st_n = 0;
      else if (power_restore && m_ag3) begin st_n = 0; wset = 1; end
    end
    m_state = st_n;
    if (reg_wr && reg_addr == 8'h00) begin
      if (reg_wdata[15]) m_wak = 0;
      if (reg_wdata[11]) m_prb = 0;
      if (reg_wdata[10]) m_rtc = 0;
    end
    if (wset) m_wak = 1;
    if (ovr) m_prb = 1;
    if (rtc_alarm) m_rtc = 1;
    if (reg_wr && reg_addr == 8'h02) begin m_rten = reg_wdata[10]; m_exen = reg_wdata[8]; end
    if (reg_wr && reg_addr == 8'h04) m_ag3 = reg_wdata[1];
    if (ovr) m_ag3 = 1;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    vectors++;
    if (reg_rdata !== m_rd) begin
      miscompares++;
      $display("FAIL %s reg_rdata actual %h expected %h", cur_req, reg_rdata, m_rd);
    end
    if (pwr_state !== 2'(m_state)) begin
      miscompares++;
      $display("FAIL %s pwr_state actual %0d expected %0d", cur_req, pwr_state, m_state);
    end
    if (wake_req !== m_wreq) begin
      miscompares++;
      $display("FAIL %s wake_req actual %0b expected %0b", cur_req, wake_req, m_wreq);
    end
    reg_wr = 0; rtc_alarm = 0; ext_wake = 0; slow_tick = 0;
    ovr_msg = 0; therm_trip = 0; power_restore = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc();
  endtask

  task automatic rd_all();
    reg_addr = 8'h00; cyc();
    reg_addr = 8'h02; cyc();
    reg_addr = 8'h04; cyc();
    reg_addr = 8'h00; cyc();
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin slow_tick = 1; cyc(); idle(2); end
  endtask

  initial begin
    // R1 power-on state
    cur_req = "R1";
    idle(3); por = 0; rd_all();
    // R2 reserved bits and unmapped offsets
    cur_req = "R2";
    wr(8'h02, 16'hFFFF); wr(8'h04, 16'hFFFE); wr(8'h00, 16'hFFFF);
    rd_all(); reg_addr = 8'h06; cyc(); reg_addr = 8'h01; cyc();
    wr(8'h04, 16'h0000); wr(8'h02, 16'h0000); reg_addr = 8'h00;
    // R5 alarm regardless of enables, R3 write-one clear
    cur_req = "R5";
    rtc_alarm = 1; cyc(); idle(2);
    cur_req = "R3";
    wr(8'h00, 16'h0000); idle(1); wr(8'h00, 16'h7BFF); idle(1);
    wr(8'h00, 16'h0400); reg_addr = 8'h00; idle(2);
    // R4 set wins over clear
    cur_req = "R4";
    rtc_alarm = 1; reg_wr = 1; reg_addr = 8'h00; reg_wdata = 16'h0400; cyc();
    idle(2); wr(8'h00, 16'h8C00); idle(1);
    // R6 sleep entry, disabled then enabled wake
    cur_req = "R6";
    wr(8'h04, 16'h0001); idle(1);
    ext_wake = 1; rtc_alarm = 1; cyc(); idle(2);
    wr(8'h02, 16'h0100); ext_wake = 1; cyc(); reg_addr = 8'h00; idle(3);
    wr(8'h00, 16'h8400); wr(8'h02, 16'h0400); wr(8'h04, 16'h0001);
    rtc_alarm = 1; cyc(); reg_addr = 8'h00; idle(2);
    wr(8'h00, 16'h8400);
    // R7 no wake flag outside sleep
    cur_req = "R7";
    wr(8'h02, 16'h0500); ext_wake = 1; cyc(); rtc_alarm = 1; cyc(); idle(1);
    wr(8'h00, 16'h0400);
    // R9 override message, then wake out of soft-off
    cur_req = "R9";
    ovr_msg = 1; cyc(); rd_all();
    cur_req = "R7";
    ext_wake = 1; cyc(); idle(2);
    // R8 hold timer with early release, then full hold held long
    cur_req = "R8";
    wr(8'h00, 16'h0800); wr(8'h04, 16'h0000);
    btn_held = 1; tick_n(HOLD - 1); btn_held = 0; idle(2);
    btn_held = 1; tick_n(HOLD - 1); idle(1); tick_n(1); rd_all();
    ext_wake = 1; cyc(); tick_n(HOLD + 2); btn_held = 0; idle(2);
    // R9 priority over sleep entry and wake
    cur_req = "R9";
    wr(8'h00, 16'h8C00);
    wr(8'h04, 16'h0001); therm_trip = 1; ext_wake = 1; cyc(); rd_all();
    ext_wake = 1; cyc();
    therm_trip = 1; reg_wr = 1; reg_addr = 8'h04; reg_wdata = 16'h0001; cyc(); rd_all();
    ext_wake = 1; cyc();
    // R10 hard reset retention
    cur_req = "R10";
    wr(8'h02, 16'h0500); wr(8'h04, 16'h0001); ext_wake = 1; cyc();
    rtc_alarm = 1; cyc(); reg_addr = 8'h00; idle(1);
    hard_rst = 1; idle(2); hard_rst = 0; rd_all();
    // R11 resume reset
    cur_req = "R11";
    resume_rst = 1; idle(2); resume_rst = 0; rd_all();
    // R12 power restore rule
    cur_req = "R12";
    power_restore = 1; cyc(); rd_all();
    wr(8'h00, 16'h8C00); wr(8'h04, 16'h0000);
    power_restore = 1; cyc(); rd_all();
    wr(8'h04, 16'h0002); ovr_msg = 1; cyc(); wr(8'h04, 16'h0002);
    power_restore = 1; cyc(); rd_all();
    wr(8'h04, 16'h0000); wr(8'h00, 16'h8C00);
    wr(8'h02, 16'h0000); wr(8'h04, 16'h0001);
    power_restore = 1; wr(8'h04, 16'h0002); idle(1); power_restore = 1; cyc(); rd_all();
    // R13 read timing around a write to the same register
    cur_req = "R13";
    reg_addr = 8'h02; cyc();
    wr(8'h02, 16'h0400); cyc(); wr(8'h02, 16'h0000); cyc();
    rtc_alarm = 1; reg_addr = 8'h00; cyc(); cyc();
    // R1 power-on clears all
    cur_req = "R1";
    por = 1; idle(2); por = 0; rd_all();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired in %s actual running expected done", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule